// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the byte address for a word load or store and, for the indexed forms, the new value that the base register should take. Each request arrives on a valid strobe. It carries an offset source, an index form, the base register value, the program counter, a second register value, a 12-bit immediate, a 5-bit left-shift amount and an add/subtract flag. The unit chooses the offset and applies the sign. It then returns the memory address, the writeback value, a writeback enable and a misalignment flag. All of these are registered and appear one cycle later, qualified by an output valid.

Memory is byte addressed with four bytes per word, so word index i lies at byte offset 4·i. The word-size parameter sets the number of low address bits that must be zero for an aligned access. The register file and the memory are outside the block. The pipeline stage that owns them uses the writeback enable to decide whether to update the base register.

Offset source encoding on `src_sel`: 0 = immediate, 1 = register, 2 = shifted register, 3 = PC-relative immediate. Index form encoding on `idx_sel`: 0 = plain, 1 = pre-indexed, 2 = post-indexed, 3 = plain.

Top module: `lsag_top`

## Requirements
- R1: With `src_sel`=0 the 12-bit immediate is zero-extended, and in plain form `mem_addr` = base ± immediate with `wb_en` low.
- R2: With `src_sel`=1 the offset is the second register value unchanged, and `shamt` has no effect on the results.
- R3: With `src_sel`=2 the second register value is shifted left logically by `shamt` (0 to 31) before use, and bits above the address width are dropped. For example, a shift of 2 multiplies the value by 4.
- R4: With `idx_sel`=1 and a non-PC source, `mem_addr` and `wb_val` both equal base ± offset, and `wb_en` is high.
- R5: With `idx_sel`=2 and a non-PC source, `mem_addr` equals the unmodified base, `wb_val` equals base ± offset, and `wb_en` is high.
- R6: With `src_sel`=3 the PC replaces the base and the immediate is the offset. The index form is ignored, `mem_addr` = PC ± immediate, and `wb_en` stays low.
- R7: `sub_n_add`=1 subtracts the offset instead of adding it. The same sign applies to `wb_val`.
- R8: `misalign` is high exactly when the low two bits of the registered `mem_addr` are nonzero. The address and writeback value are still produced in that case.
- R9: The results of a request accepted at a clock edge appear at the next edge. `out_valid` then follows `in_valid` from the previous cycle.
- R10: After a cycle with `in_valid` low, `out_valid` and `wb_en` are low, and `mem_addr`, `wb_val` and `misalign` keep their previous values.
- R11: A synchronous active-high `rst` clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_sel | input | 2 | Offset source select |
| idx_sel | input | 2 | Index form select |
| base | input | 32 | Base register value |
| pc | input | 32 | Current program counter |
| off_reg | input | 32 | Second register value used as offset |
| imm | input | 12 | Immediate offset field |
| shamt | input | 5 | Left-shift amount for the shifted register source |
| sub_n_add | input | 1 | 1 subtracts the offset, 0 adds it |
| out_valid | output | 1 | Results valid |
| mem_addr | output | 32 | Effective byte address |
| wb_val | output | 32 | Updated base value |
| wb_en | output | 1 | Base register writeback request |
| misalign | output | 1 | Address not word aligned |

## Verification
The bench sends word-indexed immediates such as 32 and 48, which show that the immediate reaches the adder unshifted and zero-extended. The all-ones immediate is also used, and it exposes any sign extension. The register source is driven with a nonzero shift amount that must have no effect, and the shifted source is driven at shift amounts 2 and 31. This separates the plain register path from the shifted one and checks truncation. Pre- and post-indexed requests use the same base and offset, so the only difference is which value appears on `mem_addr`. PC-relative requests use the indexed forms, to show that the form is ignored. A long run of pseudo-random requests mixed with idle cycles compares every field against the behavioural model, including the misalignment flag on odd addresses and the values held through idle cycles.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  typedef enum logic [1:0] {
    SRC_IMM    = 2'd0,
    SRC_REG    = 2'd1,
    SRC_SHIFT  = 2'd2,
    SRC_PCREL  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    IDX_PLAIN  = 2'd0,
    IDX_PRE    = 2'd1,
    IDX_POST   = 2'd2,
    IDX_PLAIN2 = 2'd3
  } idx_e;
endpackage

// File: rtl/lsag_offset_sel.sv
module lsag_offset_sel
  import lsag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 12,
  parameter int SHAMT_W = 5
) (
  input  src_e               src,
  input  logic [ADDR_W-1:0]  off_reg,
  input  logic [IMM_W-1:0]   imm,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [ADDR_W-1:0]  offset
);
  localparam int PAD_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] stage [SHAMT_W+1];
  logic [ADDR_W-1:0] imm_ext;

  assign stage[0] = off_reg;
  assign imm_ext  = {{PAD_W{1'b0}}, imm};

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_shift
    assign stage[k+1] = shamt[k] ? (stage[k] << (2 ** k)) : stage[k];
  end

  always_comb begin
    unique case (src)
      SRC_REG:   offset = off_reg;
      SRC_SHIFT: offset = stage[SHAMT_W];
      default:   offset = imm_ext;
    endcase
  end
endmodule

// File: rtl/lsag_addsub.sv
module lsag_addsub #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] a,
  input  logic [ADDR_W-1:0] b,
  input  logic              sub,
  output logic [ADDR_W-1:0] y
);
  logic [ADDR_W-1:0] b_eff;
  assign b_eff = sub ? ~b : b;
  assign y     = a + b_eff + {{(ADDR_W-1){1'b0}}, sub};
endmodule

// File: rtl/lsag_form.sv
module lsag_form
  import lsag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  src_e              src,
  input  idx_e              idx,
  input  logic [ADDR_W-1:0] base_eff,
  input  logic [ADDR_W-1:0] sum,
  output logic [ADDR_W-1:0] addr,
  output logic              wb_req
);
  logic from_reg;
  assign from_reg = (src != SRC_PCREL);

  always_comb begin
    addr   = sum;
    wb_req = 1'b0;
    if (from_reg) begin
      unique case (idx)
        IDX_PRE:  wb_req = 1'b1;
        IDX_POST: begin
          addr   = base_eff;
          wb_req = 1'b1;
        end
        default:  wb_req = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/lsag_top.sv
module lsag_top
  import lsag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IMM_W      = 12,
  parameter int SHAMT_W    = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         src_sel,
  input  logic [1:0]         idx_sel,
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [ADDR_W-1:0]  off_reg,
  input  logic [IMM_W-1:0]   imm,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic               sub_n_add,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [ADDR_W-1:0]  wb_val,
  output logic               wb_en,
  output logic               misalign
);
  localparam int ALIGN_W = $clog2(WORD_BYTES);

  src_e              src;
  idx_e              idx;
  logic [ADDR_W-1:0] base_eff;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] addr_n;
  logic              wb_req;

  assign src      = src_e'(src_sel);
  assign idx      = idx_e'(idx_sel);
  assign base_eff = (src == SRC_PCREL) ? pc : base;

  lsag_offset_sel #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)) u_off (
    .src(src), .off_reg(off_reg), .imm(imm), .shamt(shamt), .offset(offset)
  );

  lsag_addsub #(.ADDR_W(ADDR_W)) u_add (
    .a(base_eff), .b(offset), .sub(sub_n_add), .y(sum)
  );

  lsag_form #(.ADDR_W(ADDR_W)) u_form (
    .src(src), .idx(idx), .base_eff(base_eff), .sum(sum),
    .addr(addr_n), .wb_req(wb_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      mem_addr  <= '0;
      wb_val    <= '0;
      misalign  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= in_valid & wb_req;
      if (in_valid) begin
        mem_addr <= addr_n;
        wb_val   <= sum;
        misalign <= |addr_n[ALIGN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/lsag_checker.sv
module lsag_checker #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        src_sel,
  input logic [1:0]        idx_sel,
  input logic [ADDR_W-1:0] base,
  input logic [IMM_W-1:0]  imm,
  input logic              sub_n_add,
  input logic              out_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] wb_val,
  input logic              wb_en,
  input logic              misalign
);
  localparam int PAD_W = ADDR_W - IMM_W;

  p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_wb_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> out_valid);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wb_en && $stable(mem_addr) && $stable(wb_val)));

  p_imm_plain_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_sel == 2'd0 && idx_sel == 2'd0 && !sub_n_add) |=>
      (mem_addr == $past(base) + {{PAD_W{1'b0}}, $past(imm)} && !wb_en));

  p_pre_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_sel != 2'd3 && idx_sel == 2'd1) |=> (wb_en && wb_val == mem_addr));

  p_post_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_sel != 2'd3 && idx_sel == 2'd2) |=> (wb_en && mem_addr == $past(base)));

  p_pcrel_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_sel == 2'd3) |=> !wb_en);

  p_sub_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_sel == 2'd0 && idx_sel == 2'd1 && sub_n_add) |=>
      (wb_val == $past(base) - {{PAD_W{1'b0}}, $past(imm)}));

  p_misalign_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (misalign == (mem_addr[1:0] != 2'b00)));
endmodule

bind lsag_top lsag_checker #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .src_sel(src_sel), .idx_sel(idx_sel),
  .base(base), .imm(imm), .sub_n_add(sub_n_add), .out_valid(out_valid),
  .mem_addr(mem_addr), .wb_val(wb_val), .wb_en(wb_en), .misalign(misalign)
);

// File: tb/tb_lsag_top.sv
module tb_lsag_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  src_sel = '0;
  logic [1:0]  idx_sel = '0;
  logic [31:0] base = '0;
  logic [31:0] pc = '0;
  logic [31:0] off_reg = '0;
  logic [11:0] imm = '0;
  logic [4:0]  shamt = '0;
  logic        sub_n_add = 1'b0;
  logic        out_valid;
  logic [31:0] mem_addr;
  logic [31:0] wb_val;
  logic        wb_en;
  logic        misalign;

  int checks = 0;
  int fails  = 0;

  // Behavioural reference state
  logic        m_valid = 1'b0;
  logic [31:0] m_addr  = '0;
  logic [31:0] m_wb    = '0;
  logic        m_wben  = 1'b0;
  logic        m_mis   = 1'b0;

  always #2.5 clk = ~clk;

  lsag_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_sel(src_sel), .idx_sel(idx_sel),
    .base(base), .pc(pc), .off_reg(off_reg), .imm(imm), .shamt(shamt),
    .sub_n_add(sub_n_add), .out_valid(out_valid), .mem_addr(mem_addr),
    .wb_val(wb_val), .wb_en(wb_en), .misalign(misalign)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    check(req, "out_valid", {31'b0, out_valid}, {31'b0, m_valid});
    check(req, "mem_addr",  mem_addr, m_addr);
    check(req, "wb_val",    wb_val,   m_wb);
    check(req, "wb_en",     {31'b0, wb_en},    {31'b0, m_wben});
    check(req, "misalign",  {31'b0, misalign}, {31'b0, m_mis});
  endtask

  // Reference model: computes what the requirements say, one request at a time
  task automatic model_step();
    logic [31:0] off, b, upd;
    if (!in_valid) begin
      m_valid = 1'b0;
      m_wben  = 1'b0;
      return;
    end
    case (src_sel)
      2'd1:    off = off_reg;
      2'd2:    off = off_reg << shamt;
      default: off = {20'd0, imm};
    endcase
    b   = (src_sel == 2'd3) ? pc : base;
    upd = sub_n_add ? (b - off) : (b + off);
    m_valid = 1'b1;
    m_wb    = upd;
    if (src_sel == 2'd3) begin
      m_addr = upd;
      m_wben = 1'b0;
    end else if (idx_sel == 2'd2) begin
      m_addr = b;
      m_wben = 1'b1;
    end else begin
      m_addr = upd;
      m_wben = (idx_sel == 2'd1);
    end
    m_mis = (m_addr[1:0] != 2'b00);
  endtask

  task automatic apply(input logic v, input logic [1:0] s, input logic [1:0] x,
                       input logic [31:0] b, input logic [31:0] p, input logic [31:0] r,
                       input logic [11:0] i, input logic [4:0] sh, input logic sb,
                       input string req);
    in_valid = v; src_sel = s; idx_sel = x; base = b; pc = p;
    off_reg = r; imm = i; shamt = sh; sub_n_add = sb;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    compare_all("R11");

    // R1: word index 8 and 12 as byte offsets 32 and 48, and an all-ones immediate
    apply(1, 2'd0, 2'd0, 32'h0000_1000, 32'h0, 32'h0, 12'd32, 5'd0, 0, "R1");
    check("R1", "addr idx8", mem_addr, 32'h0000_1020);
    apply(1, 2'd0, 2'd0, 32'h0000_1000, 32'h0, 32'h0, 12'd48, 5'd0, 0, "R1");
    apply(1, 2'd0, 2'd3, 32'h0000_0000, 32'h0, 32'h0, 12'hFFF, 5'd0, 0, "R1");
    check("R1", "zero-extended imm", mem_addr, 32'h0000_0FFF);

    // R2: register offset, shift amount must have no effect
    apply(1, 2'd1, 2'd0, 32'h0000_2000, 32'h0, 32'h0000_0010, 12'd0, 5'd3, 0, "R2");
    check("R2", "shamt ignored", mem_addr, 32'h0000_2010);

    // R3: shifted register offset
    apply(1, 2'd2, 2'd0, 32'd7, 32'h0, 32'd3, 12'd0, 5'd2, 0, "R3");
    check("R3", "7+3*4", mem_addr, 32'd19);
    apply(1, 2'd2, 2'd0, 32'h0000_0100, 32'h0, 32'h0000_0003, 12'd0, 5'd31, 0, "R3");
    check("R3", "shift 31 truncates", mem_addr, 32'h8000_0100);

    // R4 / R5: same operands, pre and post forms
    apply(1, 2'd0, 2'd1, 32'h0000_4000, 32'h0, 32'h0, 12'd4, 5'd0, 0, "R4");
    check("R4", "pre addr", mem_addr, 32'h0000_4004);
    check("R4", "pre wb_en", {31'b0, wb_en}, 32'd1);
    apply(1, 2'd0, 2'd2, 32'h0000_4000, 32'h0, 32'h0, 12'd4, 5'd0, 0, "R5");
    check("R5", "post addr", mem_addr, 32'h0000_4000);
    check("R5", "post wb", wb_val, 32'h0000_4004);
    apply(1, 2'd2, 2'd1, 32'h0000_4000, 32'h0, 32'd5, 12'd0, 5'd2, 0, "R4");

    // R6: PC-relative ignores the index form
    apply(1, 2'd3, 2'd1, 32'h0000_9000, 32'h0000_0800, 32'h0, 12'd8, 5'd0, 0, "R6");
    check("R6", "pc addr", mem_addr, 32'h0000_0808);
    check("R6", "no wb_en", {31'b0, wb_en}, 32'd0);
    apply(1, 2'd3, 2'd2, 32'h0000_9000, 32'h0000_0800, 32'h0, 12'd8, 5'd0, 1, "R6");
    check("R6", "pc minus", mem_addr, 32'h0000_07F8);

    // R7: subtract with writeback
    apply(1, 2'd0, 2'd1, 32'h0000_0010, 32'h0, 32'h0, 12'd32, 5'd0, 1, "R7");
    check("R7", "wb negative", wb_val, 32'hFFFF_FFF0);

    // R8: misaligned addresses still produced
    apply(1, 2'd0, 2'd2, 32'h0000_1001, 32'h0, 32'h0, 12'd3, 5'd0, 0, "R8");
    check("R8", "misalign", {31'b0, misalign}, 32'd1);
    check("R8", "wb still made", wb_val, 32'h0000_1004);

    // R10: idle cycles hold data
    apply(0, 2'd1, 2'd1, 32'hDEAD_BEEF, 32'h0, 32'h1234_5678, 12'd7, 5'd1, 1, "R10");
    check("R10", "held addr", mem_addr, 32'h0000_1001);
    apply(0, 2'd0, 2'd0, 32'h0, 32'h0, 32'h0, 12'd0, 5'd0, 0, "R10");

    // R9: back-to-back and mixed pseudo-random traffic
    for (int n = 0; n < 400; n++) begin
      apply(($urandom % 4) != 0, 2'($urandom), 2'($urandom), $urandom, $urandom,
            $urandom, 12'($urandom), 5'($urandom), 1'($urandom), "R9");
    end

    // R11: reset mid-stream clears outputs
    in_valid = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    m_valid = 0; m_addr = 0; m_wb = 0; m_wben = 0; m_mis = 0;
    @(negedge clk);
    compare_all("R11");
    rst = 1'b0;
    in_valid = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule